// File: doc/BRIEF.md
# BCD Calendar Clock Counter Chain

This block keeps wall-clock time and calendar date as packed BCD digits. A sub-second prescaler counts enable ticks and produces one step per second. The step ripples through seconds, minutes, hours, day of month, month, two-digit year and a day-of-week counter. Hours run in 24-hour form or in 12-hour form with a PM flag. February gets its 29th day automatically in leap years.

Software loads any single digit through a narrow write port. It can freeze timekeeping, zero the prescaler, or request a 30-second adjust that rounds the time to the nearest minute. One-cycle pulses mark each second, minute and hour advance, for an interrupt block downstream. Each time unit is shown on an 8-bit output, with the tens digit in bits 7:4 and the ones digit in bits 3:0.

Top module: `bcd_clock_chain`

## Requirements
- R1: After reset the time reads 00:00:00, the date reads day 01, month 01, year 00, the week counter reads 0, and all three pulses are low.
- R2: Seconds advance by exactly one after TICKS_PER_SEC enabled ticks, and sec_pulse_o is high for one cycle with each advance.
- R3: Seconds 59 wrap to 00 and advance the minutes with a one-cycle min_pulse_o. Minutes 59 wrap to 00 and advance the hours with a one-cycle hour_pulse_o. A minute pulse only ever occurs while seconds read 00.
- R4: With mode24 high, hours count 00 to 23 with a decimal carry (09 to 10, 19 to 20), and 23:59:59 rolls to 00:00:00 while advancing the day.
- R5: With mode24 low, bit 6 of hour_o is the PM flag (1 = PM) and hours run 12, 01 … 11. The flag toggles on 11 to 12. Going from 11 PM to 12 AM also advances the day.
- R6: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in February of a non-leap year, advancing the month.
- R7: February runs to day 29 when the BCD year is a multiple of four (00, 04 … 96).
- R8: The month carries from 09 to 10, and from 12 to 01 with a year advance. The year wraps from 99 to 00.
- R9: The week counter advances on every day advance and wraps from 6 to 0.
- R10: While halt is high, ticks are ignored and the prescaler keeps its partial count for when halt drops.
- R11: A presc_clr pulse zeroes the prescaler, so the next second needs a full TICKS_PER_SEC ticks.
- R12: An adj_req pulse clears seconds. If seconds were 30 or more, it also advances the minute with full carry and pulses. A second step that falls in the same cycle is discarded, and sec_pulse_o stays low.
- R13: With wr_en high, wr_data loads the digit at wr_addr: 0/1 seconds ones/tens, 2/3 minutes, 4/5 hours, 6/7 day, 8/9 month, 10/11 year, 12 week (bits 2:0). The chain does not advance in a write cycle, and a step falling there is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sub-second enable tick |
| halt | input | 1 | Freezes the prescaler while high |
| presc_clr | input | 1 | Zeroes the prescaler |
| adj_req | input | 1 | 30-second round-to-minute request |
| mode24 | input | 1 | 1 = 24-hour, 0 = 12-hour |
| wr_en | input | 1 | Digit write strobe |
| wr_addr | input | 4 | Digit select |
| wr_data | input | 4 | Digit value |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD; bit 6 is PM in 12-hour mode |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| wday_o | output | 3 | Day of week 0..6 |
| sec_pulse_o | output | 1 | One-cycle second pulse |
| min_pulse_o | output | 1 | One-cycle minute pulse |
| hour_pulse_o | output | 1 | One-cycle hour pulse |

## Verification
The adjust request and the one-second step can land in the same cycle. The bench provokes this by issuing the last prescaler tick and raising adj_req on the cycle the step is pending. It judges the result from the outputs: seconds must read 00 and no second pulse may appear. The minute must advance only when seconds were already at 30 or above. A digit write is made to coincide with a step in the same way, and the check is that the written digit lands while seconds stay where they were.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;

  typedef enum logic [3:0] {
    A_SEC1 = 4'd0, A_SEC10 = 4'd1, A_MIN1 = 4'd2, A_MIN10 = 4'd3,
    A_HR1  = 4'd4, A_HR10  = 4'd5, A_DAY1 = 4'd6, A_DAY10 = 4'd7,
    A_MON1 = 4'd8, A_MON10 = 4'd9, A_YR1  = 4'd10, A_YR10 = 4'd11,
    A_WDAY = 4'd12
  } waddr_e;

  // value mod 4 of a two-digit BCD year: 10 mod 4 = 2
  function automatic logic bcd_leap(input digit_t y10, input digit_t y1);
    logic [1:0] r;
    r = y1[1:0] + {y10[0], 1'b0};
    return (r == 2'd0);
  endfunction

  function automatic logic [4:0] last_day(input digit_t m10, input digit_t m1,
                                          input logic leap);
    logic [4:0] mb;
    mb = (m10[0] ? 5'd10 : 5'd0) + {1'b0, m1};
    case (mb)
      5'd2:                        return leap ? 5'd29 : 5'd28;
      5'd4, 5'd6, 5'd9, 5'd11:     return 5'd30;
      default:                     return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_clk_prescale.sv
module bcd_clk_prescale #(
  parameter int TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic halt,
  input  logic clr,
  output logic step_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      step_o <= 1'b0;
    end else begin
      step_o <= 1'b0;
      if (tick_en && !halt) begin
        if (cnt == LAST) begin
          cnt    <= '0;
          step_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr) |=> ($stable(cnt) && !step_o));

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !step_o));
endmodule

// File: rtl/bcd_clk_time.sv
module bcd_clk_time
  import bcd_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       adj,
  input  logic       mode24,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  digit_t     wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       sec_pulse_o,
  output logic       min_pulse_o,
  output logic       hour_pulse_o,
  output logic       day_step_o
);
  digit_t s1, s10, m1, m10, h1, h10;
  digit_t nh1, nh10;
  logic   sec_top, min_top, do_min, do_hour, hr_day, pm;
  logic [1:0] ht;

  always_comb begin
    sec_top = (s10 == 4'd5) && (s1 == 4'd9);
    min_top = (m10 == 4'd5) && (m1 == 4'd9);
    do_min  = adj ? (s10 >= 4'd3) : (adv && sec_top);
    do_hour = do_min && min_top;
    ht      = h10[1:0];
    pm      = h10[2];
    hr_day  = 1'b0;
    nh1     = h1;
    nh10    = h10;
    if (mode24) begin
      if (ht == 2'd2 && h1 == 4'd3) begin
        nh1 = 4'd0; nh10 = 4'd0; hr_day = 1'b1;
      end else if (h1 == 4'd9) begin
        nh1 = 4'd0; nh10 = {2'b00, ht + 2'd1};
      end else begin
        nh1 = h1 + 4'd1; nh10 = {2'b00, ht};
      end
    end else begin
      if (ht == 2'd1 && h1 == 4'd1) begin
        nh1 = 4'd2; nh10 = {1'b0, ~pm, 2'b01}; hr_day = pm;
      end else if (ht == 2'd1 && h1 == 4'd2) begin
        nh1 = 4'd1; nh10 = {1'b0, pm, 2'b00};
      end else if (h1 == 4'd9) begin
        nh1 = 4'd0; nh10 = {1'b0, pm, 2'b01};
      end else begin
        nh1 = h1 + 4'd1; nh10 = {1'b0, pm, ht};
      end
    end
    day_step_o = do_hour && hr_day;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s10 <= '0; m1 <= '0; m10 <= '0; h1 <= '0; h10 <= '0;
      sec_pulse_o <= 1'b0; min_pulse_o <= 1'b0; hour_pulse_o <= 1'b0;
    end else if (wr_en) begin
      sec_pulse_o <= 1'b0; min_pulse_o <= 1'b0; hour_pulse_o <= 1'b0;
      case (wr_addr)
        A_SEC1:  s1  <= wr_data;
        A_SEC10: s10 <= wr_data;
        A_MIN1:  m1  <= wr_data;
        A_MIN10: m10 <= wr_data;
        A_HR1:   h1  <= wr_data;
        A_HR10:  h10 <= wr_data;
        default: ;
      endcase
    end else begin
      if (adj) begin
        s1 <= '0; s10 <= '0;
      end else if (adv) begin
        if (sec_top)            begin s1 <= '0; s10 <= '0; end
        else if (s1 == 4'd9)    begin s1 <= '0; s10 <= s10 + 4'd1; end
        else                    s1 <= s1 + 4'd1;
      end
      if (do_min) begin
        if (min_top)            begin m1 <= '0; m10 <= '0; end
        else if (m1 == 4'd9)    begin m1 <= '0; m10 <= m10 + 4'd1; end
        else                    m1 <= m1 + 4'd1;
      end
      if (do_hour) begin
        h1 <= nh1; h10 <= nh10;
      end
      sec_pulse_o  <= adv && !adj;
      min_pulse_o  <= do_min;
      hour_pulse_o <= do_hour;
    end
  end

  assign sec_o  = {s10, s1};
  assign min_o  = {m10, m1};
  assign hour_o = {h10, h1};

  // R3
  min_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    min_pulse_o |-> (sec_o == 8'h00));

  // R3
  hour_with_min_chk: assert property (@(posedge clk) disable iff (rst)
    hour_pulse_o |-> (min_pulse_o && min_o == 8'h00));

  // R12
  adj_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (adj && !wr_en) |=> (sec_o == 8'h00 && !sec_pulse_o));
endmodule

// File: rtl/bcd_clk_date.sv
module bcd_clk_date
  import bcd_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_step,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  digit_t     wr_data,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [2:0] wday_o
);
  digit_t d1, d10, mo1, mo10, y1, y10;
  logic [2:0] wday;
  logic       leap, day_end, mon_top, yr_top;
  logic [4:0] dlast;
  logic [5:0] dbin;

  always_comb begin
    leap    = bcd_leap(y10, y1);
    dlast   = last_day(mo10, mo1, leap);
    dbin    = {4'b0, d10[1:0]} * 6'd10 + {2'b0, d1};
    day_end = (dbin == {1'b0, dlast});
    mon_top = mo10[0] && (mo1 == 4'd2);
    yr_top  = (y10 == 4'd9) && (y1 == 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= 4'd1; d10 <= '0; mo1 <= 4'd1; mo10 <= '0;
      y1 <= '0; y10 <= '0; wday <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DAY1:  d1   <= wr_data;
        A_DAY10: d10  <= wr_data;
        A_MON1:  mo1  <= wr_data;
        A_MON10: mo10 <= wr_data;
        A_YR1:   y1   <= wr_data;
        A_YR10:  y10  <= wr_data;
        A_WDAY:  wday <= wr_data[2:0];
        default: ;
      endcase
    end else if (day_step) begin
      wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
      if (day_end) begin
        d1 <= 4'd1; d10 <= '0;
        if (mon_top) begin
          mo1 <= 4'd1; mo10 <= '0;
          if (yr_top)              begin y1 <= '0; y10 <= '0; end
          else if (y1 == 4'd9)     begin y1 <= '0; y10 <= y10 + 4'd1; end
          else                     y1 <= y1 + 4'd1;
        end else if (mo1 == 4'd9) begin
          mo1 <= '0; mo10 <= 4'd1;
        end else begin
          mo1 <= mo1 + 4'd1;
        end
      end else if (d1 == 4'd9) begin
        d1 <= '0; d10 <= d10 + 4'd1;
      end else begin
        d1 <= d1 + 4'd1;
      end
    end
  end

  assign day_o  = {d10, d1};
  assign mon_o  = {mo10, mo1};
  assign year_o = {y10, y1};
  assign wday_o = wday;

  // R9
  wday_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (day_step && !wr_en) |=> (wday != $past(wday)));

  // R6
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (day_step && !wr_en && day_end) |=> (day_o == 8'h01));
endmodule

// File: rtl/bcd_clock_chain.sv
module bcd_clock_chain #(
  parameter int TICKS_PER_SEC = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       halt,
  input  logic       presc_clr,
  input  logic       adj_req,
  input  logic       mode24,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [2:0] wday_o,
  output logic       sec_pulse_o,
  output logic       min_pulse_o,
  output logic       hour_pulse_o
);
  logic step, adv, adj, day_step;

  assign adv = step && !wr_en;
  assign adj = adj_req && !wr_en;

  bcd_clk_prescale #(.TICKS(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .halt(halt),
    .clr(presc_clr), .step_o(step)
  );

  bcd_clk_time u_time (
    .clk(clk), .rst(rst), .adv(adv), .adj(adj), .mode24(mode24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .sec_pulse_o(sec_pulse_o), .min_pulse_o(min_pulse_o),
    .hour_pulse_o(hour_pulse_o), .day_step_o(day_step)
  );

  bcd_clk_date u_date (
    .clk(clk), .rst(rst), .day_step(day_step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o)
  );

  // R2
  sec_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse_o |=> !sec_pulse_o);

  // R13
  write_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!sec_pulse_o && !min_pulse_o && !hour_pulse_o));
endmodule

// File: tb/tb_bcd_clock_chain.sv
module tb_bcd_clock_chain;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_en = 0, halt = 0, presc_clr = 0, adj_req = 0, mode24 = 1;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic [2:0] wday_o;
  logic sec_pulse_o, min_pulse_o, hour_pulse_o;

  int checks = 0, errors = 0;
  int ps = 0, pm = 0, ph = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_clock_chain #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .halt(halt),
    .presc_clr(presc_clr), .adj_req(adj_req), .mode24(mode24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o),
    .sec_pulse_o(sec_pulse_o), .min_pulse_o(min_pulse_o),
    .hour_pulse_o(hour_pulse_o)
  );

  always @(negedge clk) if (!rst) begin
    if (sec_pulse_o)  ps++;
    if (min_pulse_o)  pm++;
    if (hour_pulse_o) ph++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clr_pre();
    @(negedge clk); presc_clr = 1;
    @(negedge clk); presc_clr = 0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                         input logic [2:0] w);
    wr(0, s[3:0]);  wr(1, s[7:4]);  wr(2, m[3:0]);  wr(3, m[7:4]);
    wr(4, h[3:0]);  wr(5, h[7:4]);  wr(6, d[3:0]);  wr(7, d[7:4]);
    wr(8, mo[3:0]); wr(9, mo[7:4]); wr(10, y[3:0]); wr(11, y[7:4]);
    wr(12, {1'b0, w});
    clr_pre();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sec", sec_o, 8'h00);  chk("R1 min", min_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00); chk("R1 day", day_o, 8'h01);
    chk("R1 mon", mon_o, 8'h01);  chk("R1 year", year_o, 8'h00);
    chk("R1 wday", wday_o, 0);
    chk("R1 pulses", {sec_pulse_o, min_pulse_o, hour_pulse_o}, 0);
  endtask

  task automatic t_prescale();
    int p0;
    clr_pre(); p0 = ps;
    ticks(TPS - 1); chk("R2 not yet", sec_o, 8'h00);
    ticks(1);       chk("R2 advance", sec_o, 8'h01);
    chk("R2 one pulse", ps - p0, 1);
  endtask

  task automatic t_stop();
    ticks(2); halt = 1; ticks(6);
    chk("R10 frozen", sec_o, 8'h01);
    halt = 0; ticks(2);
    chk("R10 count kept", sec_o, 8'h02);
  endtask

  task automatic t_clr();
    ticks(2); clr_pre(); ticks(TPS - 1);
    chk("R11 restart", sec_o, 8'h02);
    ticks(1);
    chk("R11 full second", sec_o, 8'h03);
  endtask

  task automatic t_roll24();
    int m0, h0;
    mode24 = 1;
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 3'd6);
    m0 = pm; h0 = ph;
    ticks(TPS);
    chk("R4 hour wrap", hour_o, 8'h00); chk("R3 min wrap", min_o, 8'h00);
    chk("R3 sec wrap", sec_o, 8'h00);   chk("R8 day", day_o, 8'h01);
    chk("R8 month wrap", mon_o, 8'h01); chk("R8 year wrap", year_o, 8'h00);
    chk("R9 week wrap", wday_o, 0);
    chk("R3 min pulse", pm - m0, 1);    chk("R3 hour pulse", ph - h0, 1);
    set_all(8'h09, 8'h59, 8'h59, 8'h15, 8'h06, 8'h10, 3'd1);
    ticks(TPS);
    chk("R4 decimal carry", hour_o, 8'h10); chk("R4 no day", day_o, 8'h15);
    set_all(8'h19, 8'h59, 8'h59, 8'h15, 8'h06, 8'h10, 3'd1);
    ticks(TPS);
    chk("R4 19 to 20", hour_o, 8'h20);
  endtask

  task automatic t_12h();
    mode24 = 0;
    set_all(8'h11, 8'h59, 8'h59, 8'h05, 8'h03, 8'h21, 3'd2);
    ticks(TPS);
    chk("R5 11AM to 12PM", hour_o, 8'h52); chk("R5 same day", day_o, 8'h05);
    set_all(8'h52, 8'h59, 8'h59, 8'h05, 8'h03, 8'h21, 3'd2);
    ticks(TPS);
    chk("R5 12 to 1 PM", hour_o, 8'h41);
    set_all(8'h51, 8'h59, 8'h59, 8'h05, 8'h03, 8'h21, 3'd2);
    ticks(TPS);
    chk("R5 11PM to 12AM", hour_o, 8'h12); chk("R5 day adv", day_o, 8'h06);
    chk("R9 week adv", wday_o, 3);
    mode24 = 1;
  endtask

  task automatic one_day(input string tag, input logic [7:0] d, input logic [7:0] mo,
                         input logic [7:0] y, input logic [15:0] exp_dm);
    set_all(8'h23, 8'h59, 8'h59, d, mo, y, 3'd0);
    ticks(TPS);
    chk(tag, {day_o, mon_o}, {16'h0, exp_dm});
  endtask

  task automatic t_months();
    one_day("R6 april 30", 8'h30, 8'h04, 8'h21, 16'h0105);
    one_day("R6 may 30",   8'h30, 8'h05, 8'h21, 16'h3105);
    one_day("R6 nov 30",   8'h30, 8'h11, 8'h21, 16'h0112);
    one_day("R6 feb 28",   8'h28, 8'h02, 8'h25, 16'h0103);
    one_day("R7 feb 28 leap", 8'h28, 8'h02, 8'h24, 16'h2902);
    one_day("R7 feb 29 leap", 8'h29, 8'h02, 8'h24, 16'h0103);
    one_day("R7 year 00",  8'h28, 8'h02, 8'h00, 16'h2902);
    one_day("R7 year 96",  8'h28, 8'h02, 8'h96, 16'h2902);
    one_day("R8 sep to oct", 8'h30, 8'h09, 8'h21, 16'h0110);
    one_day("R8 dec 31",   8'h31, 8'h12, 8'h19, 16'h0101);
    chk("R8 year adv", year_o, 8'h20);
  endtask

  task automatic adj_pulse();
    @(negedge clk); adj_req = 1;
    @(negedge clk); adj_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic adj_on_step();
    ticks(TPS - 1);
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0; adj_req = 1;
    @(negedge clk); adj_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_adj();
    int m0, h0, s0;
    set_all(8'h05, 8'h59, 8'h45, 8'h10, 8'h03, 8'h21, 3'd0);
    h0 = ph; adj_pulse();
    chk("R12 round up", {hour_o, min_o, sec_o}, 24'h060000);
    chk("R12 hour pulse", ph - h0, 1);
    set_all(8'h05, 8'h10, 8'h29, 8'h10, 8'h03, 8'h21, 3'd0);
    m0 = pm; adj_pulse();
    chk("R12 round down", {hour_o, min_o, sec_o}, 24'h051000);
    chk("R12 no min pulse", pm - m0, 0);
    set_all(8'h05, 8'h10, 8'h29, 8'h10, 8'h03, 8'h21, 3'd0);
    s0 = ps; adj_on_step();
    chk("R12 coincide low", {min_o, sec_o}, 16'h1000);
    chk("R12 step dropped", ps - s0, 0);
    set_all(8'h05, 8'h10, 8'h45, 8'h10, 8'h03, 8'h21, 3'd0);
    adj_on_step();
    chk("R12 coincide high", {min_o, sec_o}, 16'h1100);
  endtask

  task automatic t_write();
    set_all(8'h01, 8'h02, 8'h10, 8'h10, 8'h03, 8'h21, 3'd4);
    chk("R13 map", {hour_o, min_o, sec_o, day_o, mon_o, year_o},
        48'h010210100321);
    chk("R13 week", wday_o, 4);
    ticks(TPS - 1);
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0; wr_en = 1; wr_addr = 4'd10; wr_data = 4'd5;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
    chk("R13 step lost", sec_o, 8'h10);
    chk("R13 write lands", year_o, 8'h25);
    ticks(TPS);
    chk("R13 resumes", sec_o, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_stop();
    t_clr();
    t_roll24();
    t_12h();
    t_months();
    t_adj();
    t_write();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule